// File: doc/BRIEF.md
# Programmable 16-bit CRC Engine

This block is a register-mapped accelerator that computes a 16-bit cyclic redundancy check over a stream of bytes. Software first programs the generator polynomial as two byte registers. It then issues a clear through the control register, which loads the running remainder with all zeros or all ones. The seed-select bit carried in that same control write picks which one. After that, software writes the message one byte at a time to a data port. Each write folds all eight bits into the remainder within the clock edge that accepts it.

The result is read as two bytes through an output view. The view can take the ones complement of the remainder, reverse its sixteen bits, or do both. These view options act only on the read path. They never alter the remainder itself, so software may change them at any time and read the same accumulated value in another form.

The bus is a plain synchronous register port with a write strobe, a 3-bit address, 8-bit write data and combinational 8-bit read data. Addresses: 0 control, 1 polynomial high byte, 2 polynomial low byte, 3 data input, 4 result high byte, 5 result low byte, 6 and 7 unused.

Top module: `crc16_accel`

## Requirements
- R1: After reset, the polynomial reads 0x1021 (address 1 reads 0x10, address 2 reads 0x21), the result reads 0x0000, and the control register reads 0x00.
- R2: A write to address 1 or address 2 replaces the high or low polynomial byte, and that register reads back the written value.
- R3: A control write with bit 0 (clear) set and bit 1 (seed select) clear sets the remainder to 0x0000.
- R4: A control write with bit 0 and bit 1 both set sets the remainder to 0xFFFF. A later control write that drops bit 1 without bit 0 leaves the remainder unchanged.
- R5: A write to address 3 folds the byte into the remainder MSB first. For each bit, from bit 7 down to bit 0, the feedback is remainder bit 15 XOR the data bit. The remainder is then shifted left by one, and XORed with the polynomial when the feedback is 1. The new value is readable from the cycle after the write.
- R6: When control bit 2 (invert) is set and bit 3 (flip) is clear, addresses 4 and 5 read the ones complement of the remainder, high byte and low byte respectively.
- R7: When control bit 3 is set and bit 2 is clear, the 16-bit result read is the remainder with bit i moved to bit 15-i.
- R8: When bits 2 and 3 are both set, the result read is the bit reversal of the ones complement of the remainder.
- R9: Control bit 0 always reads back as 0. Bits 1 to 3 read back as last written, and bits 7 to 4 read 0.
- R10: Writes to addresses 4 to 7 change neither the remainder nor the polynomial, and a control write without bit 0 leaves the remainder unchanged.
- R11: Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational from the registers |

## Verification
Every write takes effect at the single rising edge where bus_we is high. Read data is combinational from the registers, so each result is due in the cycle right after its write, with no further latency. The bench drives each write over one full cycle starting at a falling edge. It reads at the next falling edge, and again one nanosecond after each address change, so every sample falls after the registering edge and away from it. This holds for the clear, the byte fold, the polynomial bytes and all four output views alike.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_POLY_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_POLY_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA    = 3'd3;
    localparam logic [ADDR_W-1:0] A_RES_HI  = 3'd4;
    localparam logic [ADDR_W-1:0] A_RES_LO  = 3'd5;

    localparam int B_CLR  = 0;
    localparam int B_SEED = 1;
    localparam int B_INV  = 2;
    localparam int B_FLIP = 3;

endpackage

// File: rtl/crc16_byte_fold.sv
module crc16_byte_fold #(
    parameter int W  = 16,
    parameter int DW = 8
) (
    input  logic [W-1:0]  rem_in,
    input  logic [W-1:0]  poly,
    input  logic [DW-1:0] din,
    output logic [W-1:0]  rem_out
);
    logic [W-1:0] stage [DW+1];

    assign stage[0] = rem_in;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic fb;
        assign fb = stage[i][W-1] ^ din[DW-1-i];
        assign stage[i+1] = {stage[i][W-2:0], 1'b0} ^ (fb ? poly : '0);
    end

    assign rem_out = stage[DW];
endmodule

// File: rtl/crc16_out_view.sv
module crc16_out_view #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem,
    input  logic         inv,
    input  logic         flip,
    output logic [W-1:0] view
);
    logic [W-1:0] cpl;
    logic [W-1:0] rev;

    assign cpl = inv ? ~rem : rem;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = cpl[W-1-i];
    end

    assign view = flip ? rev : cpl;
endmodule

// File: rtl/crc16_accel.sv
module crc16_accel
    import crc16_pkg::*;
#(
    parameter logic [15:0] POLY_INIT = 16'h1021
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata
);
    logic [CRC_W-1:0] poly_q;
    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] rem_fold;
    logic [CRC_W-1:0] res_view;
    logic             seed_q;
    logic             inv_q;
    logic             flip_q;

    crc16_byte_fold #(.W(CRC_W), .DW(BYTE_W)) fold_i (
        .rem_in  (rem_q),
        .poly    (poly_q),
        .din     (bus_wdata),
        .rem_out (rem_fold)
    );

    crc16_out_view #(.W(CRC_W)) view_i (
        .rem  (rem_q),
        .inv  (inv_q),
        .flip (flip_q),
        .view (res_view)
    );

    // Register updates: one write per cycle, decoded by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poly_q <= POLY_INIT;
            rem_q  <= '0;
            seed_q <= 1'b0;
            inv_q  <= 1'b0;
            flip_q <= 1'b0;
        end else if (bus_we) begin
            case (bus_addr)
                A_CTRL: begin
                    seed_q <= bus_wdata[B_SEED];
                    inv_q  <= bus_wdata[B_INV];
                    flip_q <= bus_wdata[B_FLIP];
                    if (bus_wdata[B_CLR])
                        rem_q <= bus_wdata[B_SEED] ? '1 : '0;
                end
                A_POLY_HI: poly_q[15:8] <= bus_wdata;
                A_POLY_LO: poly_q[7:0]  <= bus_wdata;
                A_DATA:    rem_q        <= rem_fold;
                default: ;
            endcase
        end
    end

    // Read mux.
    always_comb begin
        case (bus_addr)
            A_CTRL:    bus_rdata = {4'b0, flip_q, inv_q, seed_q, 1'b0};
            A_POLY_HI: bus_rdata = poly_q[15:8];
            A_POLY_LO: bus_rdata = poly_q[7:0];
            A_RES_HI:  bus_rdata = res_view[15:8];
            A_RES_LO:  bus_rdata = res_view[7:0];
            default:   bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/crc16_accel_chk.sv
module crc16_accel_chk
    import crc16_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [15:0] rem,
    input logic [15:0] poly,
    input logic        inv,
    input logic        flip
);
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL && bus_wdata[B_CLR] && !bus_wdata[B_SEED])
        |=> rem == 16'h0000);

    a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL && bus_wdata[B_CLR] && bus_wdata[B_SEED])
        |=> rem == 16'hFFFF);

    a_r10_ctrl_keeps_rem: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL && !bus_wdata[B_CLR]) |=> $stable(rem));

    a_r10_high_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[2]) |=> ($stable(rem) && $stable(poly)));

    a_r6_invert_view: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_RES_HI && inv && !flip) |-> bus_rdata == ~rem[15:8]);

    a_r7_flip_view: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_RES_LO && flip && !inv) |-> bus_rdata == {<<{rem[15:8]}});

    a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> (bus_rdata[B_CLR] == 1'b0 && bus_rdata[7:4] == 4'h0));

    a_r11_data_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DATA) |-> bus_rdata == 8'h00);
endmodule

bind crc16_accel crc16_accel_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rem       (rem_q),
    .poly      (poly_q),
    .inv       (inv_q),
    .flip      (flip_q)
);

// File: tb/crc16_accel_tb_top.sv
`timescale 1ns/1ps
module crc16_accel_tb_top;
    localparam logic [2:0] T_CTRL = 3'd0, T_PH = 3'd1, T_PL = 3'd2, T_DIN = 3'd3,
                           T_RH = 3'd4, T_RL = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    crc16_accel dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] ref_step(logic [15:0] r, logic [15:0] p, logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[15] ^ b[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ p;
        end
        return r;
    endfunction

    function automatic logic [15:0] ref_view(logic [15:0] r, logic iv, logic fl);
        logic [15:0] v;
        logic [15:0] o;
        v = iv ? ~r : r;
        for (int i = 0; i < 16; i++) o[i] = v[15-i];
        return fl ? o : v;
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h, l;
        rd(T_RH, h);
        rd(T_RL, l);
        v = {h, l};
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0]  b8;
        logic [15:0] v16;
        logic [15:0] model;
        logic [15:0] polys [3];
        polys[0] = 16'h1021; polys[1] = 16'h8005; polys[2] = 16'h3D65;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(T_CTRL, b8); check("R1 ctrl", {8'h0, b8}, 16'h0000);
        rd(T_PH, b8);   check("R1 poly hi", {8'h0, b8}, 16'h0010);
        rd(T_PL, b8);   check("R1 poly lo", {8'h0, b8}, 16'h0021);
        rd16(v16);      check("R1 result", v16, 16'h0000);

        // R2 polynomial readback
        wr(T_PH, 8'hA5); wr(T_PL, 8'h3C);
        rd(T_PH, b8); check("R2 poly hi", {8'h0, b8}, 16'h00A5);
        rd(T_PL, b8); check("R2 poly lo", {8'h0, b8}, 16'h003C);

        // R9 control readback, clear bit reads 0
        wr(T_CTRL, 8'hFE);
        rd(T_CTRL, b8); check("R9 ctrl no clear", {8'h0, b8}, 16'h000E);
        rd16(v16); check("R10 ctrl w/o clear keeps rem", v16, ref_view(16'h0000, 1'b1, 1'b1));
        wr(T_CTRL, 8'h03);
        rd(T_CTRL, b8); check("R9 clear reads 0", {8'h0, b8}, 16'h0002);
        rd16(v16); check("R4 seed ones", v16, 16'hFFFF);
        wr(T_CTRL, 8'h00);
        rd16(v16); check("R4 seed kept after drop", v16, 16'hFFFF);
        wr(T_CTRL, 8'h01);
        rd16(v16); check("R3 seed zero", v16, 16'h0000);

        // R11 data address reads 0
        wr(T_DIN, 8'h5A);
        rd(T_DIN, b8); check("R11 data reads 0", {8'h0, b8}, 16'h0000);

        // Main sweep: polynomials x seeds x views (R5..R8, R3, R4)
        for (int pi = 0; pi < 3; pi++) begin
            for (int sd = 0; sd < 2; sd++) begin
                for (int md = 0; md < 4; md++) begin
                    logic iv, fl;
                    iv = md[0]; fl = md[1];
                    wr(T_PH, polys[pi][15:8]);
                    wr(T_PL, polys[pi][7:0]);
                    wr(T_CTRL, {4'h0, fl, iv, sd[0], 1'b1});
                    wr(T_CTRL, {4'h0, fl, iv, 1'b0, 1'b0});
                    model = sd[0] ? 16'hFFFF : 16'h0000;
                    rd16(v16);
                    check(sd[0] ? "R4 seed view" : "R3 seed view", v16, ref_view(model, iv, fl));
                    for (int k = 0; k < 12; k++) begin
                        logic [7:0] db;
                        db = 8'((k * 37 + pi * 11 + sd * 101 + md * 7) & 8'hFF);
                        wr(T_DIN, db);
                        model = ref_step(model, polys[pi], db);
                        rd16(v16);
                        case (md)
                            0: check("R5 fold", v16, ref_view(model, iv, fl));
                            1: check("R6 invert", v16, ref_view(model, iv, fl));
                            2: check("R7 flip", v16, ref_view(model, iv, fl));
                            default: check("R8 invert+flip", v16, ref_view(model, iv, fl));
                        endcase
                    end
                end
            end
        end

        // Exhaustive single byte sweep, polynomial 0x8005 (R5)
        wr(T_PH, 8'h80); wr(T_PL, 8'h05);
        for (int b = 0; b < 256; b++) begin
            wr(T_CTRL, 8'h01);
            wr(T_DIN, 8'(b));
            rd16(v16);
            check("R5 single byte", v16, ref_step(16'h0000, 16'h8005, 8'(b)));
        end

        // R10 ignored writes
        model = ref_step(16'h0000, 16'h8005, 8'hFF);
        wr(T_RH, 8'h12); wr(T_RL, 8'h34); wr(3'd6, 8'h56); wr(3'd7, 8'h78);
        rd16(v16); check("R10 result unchanged", v16, model);
        rd(T_PH, b8); check("R10 poly hi unchanged", {8'h0, b8}, 16'h0080);
        rd(T_PL, b8); check("R10 poly lo unchanged", {8'h0, b8}, 16'h0005);
        wr(T_CTRL, 8'h02);
        rd16(v16); check("R10 ctrl w/o clear", v16, model);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule